// File: doc/BRIEF.md
# Tagged Point-to-Point FIFO Link

This block is a one-way, single-clock queue that joins one producer to one consumer with no arbitration. Every entry carries a data word of configurable width plus one sideband tag bit. The producer may use the tag to mark frame edges or control words. The consumer always sees the head entry, its tag and a valid flag, with no read request. A read acknowledges that head entry and moves the queue on.

Two storage timings are offered. The register style shows a word written into an empty queue right after that write edge. The RAM style reads its storage synchronously, so the valid flag comes up one edge later. A requested depth of 2 to 15 is built as 16 entries. A depth of 1 is kept as 1. The block contains its own reset stretcher. It holds the queue in reset for a fixed number of cycles after the external reset goes away, and it drives that stretched reset out to attached logic. Three status flags are provided so that they can be wired to an interrupt controller.

Top module: `p2p_tag_fifo`

## Requirements
- R1: Data and tag travel together, and entries leave in the order they were written. Bit 16 of a bench queue entry is the tag and bits 15:0 are the data.
- R2: `rd_data`, `rd_tag` and `rd_exists` show the head entry without any read request. After a read edge they show the next entry, or `rd_exists` goes to 0 if the queue became empty.
- R3: With `RAM_STYLE=0`, a word written into an empty queue is on `rd_data` with `rd_exists`=1 right after that write edge.
- R4: With `RAM_STYLE=1`, `rd_exists` stays 0 after the edge that writes into an empty queue. It rises after the following edge.
- R5: `wr_full` is 1 exactly when the number of held entries equals the built depth. A read from a full queue with no write drops `wr_full` after that edge, so the producer can write on the next edge.
- R6: The built depth is 1 for a requested depth of 1. It is 16 for a requested depth of 2 to 15, and it equals the request from 16 up to 8192.
- R7: A write and a read on the same edge, with the queue neither empty nor full, leave the occupancy unchanged. The written entry goes behind all older entries.
- R8: With `CTRL_EN=0`, `rd_tag` and `irq_tag_head` are always 0, whatever is written on `wr_tag`.
- R9: `link_rst` is 1 while the external reset is active. It goes to 0 after the 17th rising edge at which the external reset is sampled inactive. `RST_ACT_HIGH` selects the active level of `ext_rst`: 1 means active high, 0 means active low.
- R10: While `link_rst` is 1, the queue is emptied: `rd_exists`=0 and `wr_full`=0.
- R11: `irq_has_data` equals `rd_exists`, and `irq_full` equals `wr_full`. `irq_tag_head` is 1 exactly when `rd_exists` is 1 and `rd_tag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| ext_rst | input | 1 | External reset, level set by `RST_ACT_HIGH` |
| link_rst | output | 1 | Stretched reset, active high, for attached logic |
| wr_data | input | DATA_W | Producer data word |
| wr_tag | input | 1 | Producer sideband tag |
| wr_en | input | 1 | Push data and tag at the rising edge |
| wr_full | output | 1 | Queue holds its built depth |
| rd_data | output | DATA_W | Head entry data |
| rd_tag | output | 1 | Head entry tag (0 when `CTRL_EN=0`) |
| rd_en | input | 1 | Pop the head entry at the rising edge |
| rd_exists | output | 1 | Head entry is valid |
| irq_has_data | output | 1 | Status: queue has data |
| irq_full | output | 1 | Status: queue full |
| irq_tag_head | output | 1 | Status: valid head entry carries tag 1 |

## Verification
The embedded properties check several rules on every cycle. The occupancy never passes the built depth, and a combined write and read keeps it steady. A read from a full queue clears the full flag. A write into an empty queue shows up after one edge in register style and after two in RAM style. The stretched reset is held while the external reset is active, and the stretched reset empties the queue. The scenarios are needed to show the rest. They check FIFO order and the pairing of tag and data against a reference queue. They check the exact 17-cycle release count under both reset polarities, and that requested depth 3 is built as 16 while depth 1 stays 1. They check that the tag is forced to zero when it is disabled, and that the status flags follow the head entry.

// File: rtl/p2p_tag_pkg.sv
package p2p_tag_pkg;

  // Built depth for a requested depth: 1 stays 1, 2..15 round up to 16.
  function automatic int eff_depth(input int req);
    if (req <= 1)   return 1;
    if (req < 16)   return 16;
    if (req > 8192) return 8192;
    return req;
  endfunction

  // Pointer width, never below one bit.
  function automatic int ptr_bits(input int depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction

  // Occupancy width able to hold 0..depth.
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/p2p_rst_stretch.sv
module p2p_rst_stretch #(
  parameter int STRETCH  = 17,
  parameter int ACT_HIGH = 1
) (
  input  logic clk,
  input  logic ext_rst_i,
  output logic rst_o
);
  localparam int CW = $clog2(STRETCH + 1);

  logic          ext_act;
  logic [CW-1:0] hold_cnt;
  logic          rst_q;

  assign ext_act = (ACT_HIGH != 0) ? ext_rst_i : !ext_rst_i;

  always_ff @(posedge clk) begin
    if (ext_act) begin
      hold_cnt <= '0;
      rst_q    <= 1'b1;
    end else if (hold_cnt != CW'(STRETCH)) begin
      hold_cnt <= hold_cnt + 1'b1;
      if (hold_cnt == CW'(STRETCH - 1)) rst_q <= 1'b0;
    end
  end

  assign rst_o = rst_q;

  AST_EXT_HOLDS_RST: assert property (@(posedge clk) ext_act |=> rst_q); // R9
  AST_RELEASE_QUIET: assert property (@(posedge clk) $fell(rst_q) |-> !$past(ext_act)); // R9

endmodule

// File: rtl/p2p_ptr_ctl.sv
module p2p_ptr_ctl
  import p2p_tag_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = ptr_bits(DEPTH),
  parameter int CW    = cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          head_vis,
  output logic          push_ev,
  output logic          pop_ev,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] rd_ptr_nxt,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          occ_nz,
  output logic          remain_nz
);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign occ_nz    = (count != '0);
  assign push_ev   = wr_en && !full;
  assign pop_ev    = rd_en && head_vis;
  assign rd_ptr_nxt = pop_ev ? bump(rd_ptr) : rd_ptr;
  assign remain_nz = ((count - CW'(pop_ev)) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ev) wr_ptr <= bump(wr_ptr);
      rd_ptr <= rd_ptr_nxt;
      case ({push_ev, pop_ev})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R5
  AST_BOTH_KEEP_OCC: assert property (@(posedge clk) disable iff (rst) (push_ev && pop_ev) |=> $stable(count)); // R7
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst) (full && pop_ev && !push_ev) |=> !full); // R5
  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (count == '0)); // R10

endmodule

// File: rtl/p2p_entry_mem.sv
module p2p_entry_mem #(
  parameter int EW        = 33,
  parameter int DEPTH     = 16,
  parameter int PW        = 4,
  parameter int RAM_STYLE = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  input  logic [PW-1:0] raddr_nxt,
  input  logic          occ_nz,
  input  logic          remain_nz,
  output logic [EW-1:0] head,
  output logic          head_vis
);

  logic [EW-1:0] store [DEPTH];

  // Storage is never reset.
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  generate
    if (RAM_STYLE == 0) begin : g_reg
      // Asynchronous read: the head is visible as soon as it is counted.
      logic unused_ram_side;
      assign unused_ram_side = ^{raddr_nxt, remain_nz, rst};
      assign head     = store[raddr];
      assign head_vis = occ_nz;
    end else begin : g_ram
      // Synchronous read of the next head. An entry counts as visible only
      // if it was already stored before the edge that loads it.
      logic [EW-1:0] head_q;
      logic          vis_q;
      logic          unused_reg_side;
      assign unused_reg_side = ^{raddr, occ_nz};
      always_ff @(posedge clk) begin
        head_q <= store[raddr_nxt];
        vis_q  <= rst ? 1'b0 : remain_nz;
      end
      assign head     = head_q;
      assign head_vis = vis_q;
    end
  endgenerate

endmodule

// File: rtl/p2p_tag_fifo.sv
module p2p_tag_fifo
  import p2p_tag_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DEPTH_REQ    = 16,
  parameter int CTRL_EN      = 1,
  parameter int RAM_STYLE    = 0,
  parameter int RST_ACT_HIGH = 1,
  parameter int RST_EXTRA    = 17
) (
  input  logic              clk,
  input  logic              ext_rst,
  output logic              link_rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_tag,
  input  logic              wr_en,
  output logic              wr_full,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  input  logic              rd_en,
  output logic              rd_exists,
  output logic              irq_has_data,
  output logic              irq_full,
  output logic              irq_tag_head
);
  localparam int DEPTH = eff_depth(DEPTH_REQ);
  localparam int PW    = ptr_bits(DEPTH);
  localparam int CW    = cnt_bits(DEPTH);
  localparam int EW    = DATA_W + ((CTRL_EN != 0) ? 1 : 0);

  // Internal events, named for the assertions.
  logic          push_ev, pop_ev, full_w, occ_nz, remain_nz, head_vis;
  logic [PW-1:0] wr_ptr, rd_ptr, rd_ptr_nxt;
  logic [CW-1:0] count;
  logic [EW-1:0] wentry, head;

  p2p_rst_stretch #(.STRETCH(RST_EXTRA), .ACT_HIGH(RST_ACT_HIGH)) u_rst (
    .clk(clk), .ext_rst_i(ext_rst), .rst_o(link_rst)
  );

  p2p_ptr_ctl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ptr (
    .clk(clk), .rst(link_rst), .wr_en(wr_en), .rd_en(rd_en), .head_vis(head_vis),
    .push_ev(push_ev), .pop_ev(pop_ev), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .rd_ptr_nxt(rd_ptr_nxt), .count(count), .full(full_w), .occ_nz(occ_nz),
    .remain_nz(remain_nz)
  );

  p2p_entry_mem #(.EW(EW), .DEPTH(DEPTH), .PW(PW), .RAM_STYLE(RAM_STYLE)) u_mem (
    .clk(clk), .rst(link_rst), .we(push_ev), .waddr(wr_ptr), .wdata(wentry),
    .raddr(rd_ptr), .raddr_nxt(rd_ptr_nxt), .occ_nz(occ_nz), .remain_nz(remain_nz),
    .head(head), .head_vis(head_vis)
  );

  generate
    if (CTRL_EN != 0) begin : g_tag
      assign wentry = {wr_tag, wr_data};
      assign rd_tag = head[EW-1] & head_vis;
    end else begin : g_notag
      logic unused_tag;
      assign unused_tag = wr_tag;
      assign wentry = wr_data;
      assign rd_tag = 1'b0;
    end
  endgenerate

  assign rd_data      = head[DATA_W-1:0];
  assign rd_exists    = head_vis;
  assign wr_full      = full_w;
  assign irq_has_data = head_vis;
  assign irq_full     = full_w;
  assign irq_tag_head = rd_tag & head_vis;

  generate
    if (RAM_STYLE == 0) begin : g_chk_reg
      AST_SHOW_AT_ONCE: assert property (@(posedge clk) disable iff (link_rst)
        (count == '0 && wr_en) |=> rd_exists); // R3
    end else begin : g_chk_ram
      AST_RAM_BUBBLE: assert property (@(posedge clk) disable iff (link_rst)
        (count == '0 && wr_en) |=> !rd_exists); // R4
    end
  endgenerate

  AST_RST_EMPTIES: assert property (@(posedge clk) link_rst |=> (!rd_exists || link_rst) && !wr_full); // R10

endmodule

// File: tb/sim_p2p_tag_fifo.sv
`timescale 1ns/1ps
module sim_p2p_tag_fifo;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // u0: register style, requested depth 3 (built 16), tag on, active-high reset
  logic        a_rst = 1'b1, a_lrst, a_wr = 0, a_tag = 0, a_full, a_rd = 0, a_ex, a_rtag;
  logic        a_ihd, a_ifl, a_itg;
  logic [15:0] a_wd = '0, a_rdd;
  // u1: RAM style, depth 1, tag off, active-low reset
  logic        b_rstn = 1'b0, b_lrst, b_wr = 0, b_tag = 0, b_full, b_rd = 0, b_ex, b_rtag;
  logic        b_ihd, b_ifl, b_itg;
  logic [15:0] b_wd = '0, b_rdd;

  p2p_tag_fifo #(.DATA_W(16), .DEPTH_REQ(3), .CTRL_EN(1), .RAM_STYLE(0), .RST_ACT_HIGH(1)) u0 (
    .clk(clk), .ext_rst(a_rst), .link_rst(a_lrst), .wr_data(a_wd), .wr_tag(a_tag),
    .wr_en(a_wr), .wr_full(a_full), .rd_data(a_rdd), .rd_tag(a_rtag), .rd_en(a_rd),
    .rd_exists(a_ex), .irq_has_data(a_ihd), .irq_full(a_ifl), .irq_tag_head(a_itg));

  p2p_tag_fifo #(.DATA_W(16), .DEPTH_REQ(1), .CTRL_EN(0), .RAM_STYLE(1), .RST_ACT_HIGH(0)) u1 (
    .clk(clk), .ext_rst(b_rstn), .link_rst(b_lrst), .wr_data(b_wd), .wr_tag(b_tag),
    .wr_en(b_wr), .wr_full(b_full), .rd_data(b_rdd), .rd_tag(b_rtag), .rd_en(b_rd),
    .rd_exists(b_ex), .irq_has_data(b_ihd), .irq_full(b_ifl), .irq_tag_head(b_itg));

  logic [16:0] mq[$];   // reference queue for u0: {tag, data}

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // One u0 step: drive at a negedge, model at the edge, inputs idle afterwards.
  task automatic step0(input bit w, input bit r, input bit t, input logic [15:0] d);
    a_wr = w; a_rd = r; a_tag = t; a_wd = d;
    @(posedge clk);
    if (r && mq.size() != 0) void'(mq.pop_front());
    if (w && mq.size() < 16) mq.push_back({t, d});
    @(negedge clk);
    a_wr = 0; a_rd = 0;
  endtask

  task automatic check_head0(input string req);
    bit he = (mq.size() != 0);
    chk(a_ex == he, req, "rd_exists", a_ex, he);
    chk(a_full == (mq.size() == 16), "R5", "wr_full", a_full, mq.size() == 16);
    if (he) begin
      chk(a_rdd == mq[0][15:0], req, "rd_data", a_rdd, mq[0][15:0]);
      chk(a_rtag == mq[0][16], "R1", "rd_tag", a_rtag, mq[0][16]);
      chk(a_itg == mq[0][16], "R11", "irq_tag_head", a_itg, mq[0][16]);
    end else begin
      chk(a_itg == 1'b0, "R11", "irq_tag_head empty", a_itg, 0);
    end
    chk(a_ihd == a_ex && a_ifl == a_full, "R11", "status flags", {a_ihd, a_ifl}, {a_ex, a_full});
  endtask

  // {wr, rd, tag, exp_exists, data[15:0]}
  localparam logic [19:0] VEC [13] = '{
    20'hBA001, 20'h9A002, 20'hFA003, 20'h50000, 20'h40000,
    20'h9B001, 20'hFB002, 20'h40000, 20'hBC001, 20'h10000,
    20'h9C002, 20'h50000, 20'h40000
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    // Reset state (R10) and release timing (R9) for both polarities
    repeat (4) @(negedge clk);
    chk(a_lrst == 1 && b_lrst == 1, "R9", "link_rst during ext reset", {a_lrst, b_lrst}, 2'b11);
    chk(a_ex == 0 && a_full == 0, "R10", "u0 empty in reset", {a_ex, a_full}, 0);
    chk(b_ex == 0 && b_full == 0, "R10", "u1 empty in reset", {b_ex, b_full}, 0);
    a_rst = 1'b0; b_rstn = 1'b1;
    repeat (16) @(posedge clk);
    @(negedge clk);
    chk(a_lrst == 1 && b_lrst == 1, "R9", "held after 16 edges", {a_lrst, b_lrst}, 2'b11);
    @(posedge clk);
    @(negedge clk);
    chk(a_lrst == 0 && b_lrst == 0, "R9", "released after 17 edges", {a_lrst, b_lrst}, 0);
    check_head0("R10");

    // Vector table: R1, R2, R3, R7 against the reference queue
    for (int i = 0; i < 13; i++) begin
      step0(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][15:0]);
      chk(a_ex == VEC[i][16], "R2", "table exists", a_ex, VEC[i][16]);
      check_head0(i == 0 ? "R3" : (i == 2 || i == 6) ? "R7" : "R2");
    end

    // Fill: requested depth 3 is built as 16 (R6), full handshake (R5)
    for (int i = 0; i < 16; i++) begin
      step0(1, 0, i[0], 16'h5000 + 16'(i));
      if (i == 14) chk(a_full == 0, "R6", "not full at 15", a_full, 0);
      if (i == 15) chk(a_full == 1, "R6", "full at 16", a_full, 1);
    end
    step0(0, 1, 0, 0);
    chk(a_full == 0, "R5", "full drops after pop", a_full, 0);
    step0(1, 0, 1, 16'h5EEE);
    chk(a_full == 1, "R5", "refilled to full", a_full, 1);
    for (int i = 0; i < 16; i++) begin
      step0(0, 1, 0, 0);
      check_head0("R1");
    end

    // Random bursts that respect full and exists
    for (int i = 0; i < 400; i++) begin
      bit w = ($urandom % 3 != 0) && !a_full;
      bit r = ($urandom % 2 == 0) && a_ex;
      step0(w, r, 1'($urandom), 16'($urandom));
      check_head0(w && r ? "R7" : "R1");
    end
    while (mq.size() != 0) begin
      step0(0, 1, 0, 0);
      check_head0("R2");
    end

    // u1: RAM-style latency (R4), depth 1 (R6), tag forced to 0 (R8)
    b_wr = 1; b_tag = 1; b_wd = 16'hBEEF;
    @(posedge clk); @(negedge clk);
    b_wr = 0;
    chk(b_ex == 0, "R4", "exists still low after write edge", b_ex, 0);
    chk(b_full == 1, "R6", "depth 1 full after one write", b_full, 1);
    @(posedge clk); @(negedge clk);
    chk(b_ex == 1, "R4", "exists one edge later", b_ex, 1);
    chk(b_rdd == 16'hBEEF, "R4", "ram head data", b_rdd, 16'hBEEF);
    chk(b_rtag == 0 && b_itg == 0, "R8", "tag disabled", {b_rtag, b_itg}, 0);
    b_rd = 1;
    @(posedge clk); @(negedge clk);
    b_rd = 0;
    chk(b_ex == 0 && b_full == 0, "R5", "u1 empty after pop", {b_ex, b_full}, 0);
    b_wr = 1; b_tag = 1; b_wd = 16'h1234;
    @(posedge clk); @(negedge clk);
    b_wr = 0;
    @(posedge clk); @(negedge clk);
    chk(b_ex == 1 && b_rdd == 16'h1234, "R4", "second word", {b_ex, b_rdd}, {1'b1, 16'h1234});
    chk(b_rtag == 0, "R8", "tag disabled again", b_rtag, 0);

    // Reset mid-stream empties u0 (R10)
    step0(1, 0, 1, 16'h7001);
    step0(1, 0, 0, 16'h7002);
    a_rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mq.delete();
    chk(a_lrst == 1, "R9", "link_rst on mid reset", a_lrst, 1);
    chk(a_ex == 0 && a_full == 0 && a_ihd == 0, "R10", "u0 cleared", {a_ex, a_full, a_ihd}, 0);
    a_rst = 1'b0;
    repeat (18) @(posedge clk);
    @(negedge clk);
    chk(a_lrst == 0, "R9", "released again", a_lrst, 0);
    check_head0("R10");

    finish_up();
  end
endmodule